// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block gathers every interrupt source of a single UART channel. It masks each source with its own enable bit and reports the most urgent pending source as a 6-bit identification code. It also drives the channel's interrupt request line, which has an output-enable. The block does not detect line events itself. The receive/transmit logic, the receive queue and the register decoder report those events to it as single-cycle pulses or as levels. The decoder also passes in strobes for reads of the identification, line-status, receive-data and modem-status registers, and for writes to the transmit holding register.

Each source keeps its own pending state and clears by its own rule. For example, a read of the modem-status register clears only the modem source. The end of an identification read clears only the source that the read returned. The block counts the erroneous characters held in the receive queue, so its error summary flag stays set until the last bad character has been popped. It also masks the error bits of the character at the head of the queue, so that they read as zero when the queue is empty.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `ident_code` is 000001, `irq_out` is 0 and `irq_oe` is 0. All enables are cleared, so a source event raises no interrupt until an enable is written.
- R2: Code values are: none = 000001, line status = 000110, receive timeout = 001100, receive data = 000100, transmit empty = 000010, modem status = 000000, Xoff/special = 010000, CTS/RTS change = 100000. Priority from highest to lowest is: line status, timeout, receive data, transmit, modem, Xoff, CTS/RTS change. Timeout beats receive data at their shared level. `ident_code` is registered and shows a latched source event two cycles after its pulse.
- R3: `err_any` is 1 exactly while at least one character with a nonzero error field is in the receive queue. It rises one cycle after such a push and falls one cycle after the last one is popped. The line-status source is pending while `err_any` is set or an overrun is latched. A line-status read clears the overrun.
- R4: `head_err` equals `rxq_head_err` while the queue is non-empty and is 000 while `rxq_empty` is 1, whatever the head input holds.
- R5: The timeout source latches on `timeout_evt` and is cleared by a data read. The receive-data source follows the `rx_data_cond` level.
- R6: The transmit source latches on `tx_empty_evt`. It clears on `wr_thr`, or at the end of an identification read that returned 000010.
- R7: The modem source latches on `modem_evt` and clears on a modem-status read.
- R8: An Xoff raised by `xoff_evt` clears only on `xon_evt`; an identification read does not clear it. An Xoff raised by `special_evt` ignores `xon_evt` and clears at the end of an identification read that returned 010000.
- R9: The CTS/RTS change source latches on `flow_evt` and clears at the end of an identification read that returned 100000.
- R10: `ident_code` does not change while `rd_ident` is 1. A clear caused by an identification read acts on the end of the read (the first cycle with `rd_ident` back at 0), and only on the source whose code was frozen.
- R11: `irq_out` is the OR of all enabled pending sources. Enable bits are [0] receive data and timeout, [1] transmit, [2] line status, [3] modem, [4] Xoff, [5] CTS/RTS change. A disabled source neither drives `irq_out` nor appears in `ident_code`. Event inputs take priority over clear strobes in the same cycle.
- R12: `irq_oe` is a register that becomes 1 one cycle after `irq_gate` or `irq_force` is 1, and 0 one cycle after both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| wr_ien | input | 1 | Write strobe for the enable mask |
| ien_wdata | input | 6 | New enable mask |
| rd_ident | input | 1 | Identification read access, held for the whole access |
| rd_status | input | 1 | Line-status read strobe |
| rd_data | input | 1 | Receive-data read strobe |
| rd_modem | input | 1 | Modem-status read strobe |
| wr_thr | input | 1 | Transmit holding register write strobe |
| overrun_evt | input | 1 | Overrun detected pulse |
| timeout_evt | input | 1 | Receive timeout pulse |
| rx_data_cond | input | 1 | Receive data available level |
| tx_empty_evt | input | 1 | Transmit holding empty pulse |
| modem_evt | input | 1 | Modem status change pulse |
| xoff_evt | input | 1 | Xoff flow character detected pulse |
| xon_evt | input | 1 | Xon flow character detected pulse |
| special_evt | input | 1 | Special character detected pulse |
| flow_evt | input | 1 | CTS/RTS active-to-inactive pulse |
| rxq_push | input | 1 | Character written into receive queue |
| rxq_push_err | input | 3 | Error field of the pushed character |
| rxq_pop | input | 1 | Head character read out of receive queue |
| rxq_empty | input | 1 | Receive queue is empty |
| rxq_head_err | input | 3 | Error field of the head character |
| irq_gate | input | 1 | Control bit enabling the interrupt output |
| irq_force | input | 1 | Force-enable input for the interrupt output |
| ident_code | output | 6 | Identification code |
| irq_out | output | 1 | Interrupt request value |
| irq_oe | output | 1 | Interrupt output enable (0 = high impedance) |
| err_any | output | 1 | Error anywhere in the receive queue |
| head_err | output | 3 | Error field of the head character, zero when empty |

## Verification
A source latch is set on the clock edge that samples its event pulse. `irq_out` therefore shows it one cycle after the pulse, and `ident_code` shows it one edge later (two cycles), because the code register samples the latches. `err_any` and `irq_oe` are due one cycle after their stimulus. `head_err` is combinational and is due as soon as the queue inputs change. The bench drives every input on the falling edge and steps its reference model on the rising edge. It then compares `ident_code`, `irq_out`, `err_any` and `irq_oe` at the next falling edge, and compares `head_err` a short delay after the new queue inputs are applied. Each result is therefore checked in the cycle that the counts above predict.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  // enable mask bit positions
  localparam int EN_RX = 0;
  localparam int EN_TX = 1;
  localparam int EN_LS = 2;
  localparam int EN_MS = 3;
  localparam int EN_XF = 4;
  localparam int EN_FC = 5;
  localparam int EN_W  = 6;
  localparam int ID_W  = 6;

  localparam logic [ID_W-1:0] ID_NONE = 6'b000001;
  localparam logic [ID_W-1:0] ID_LS   = 6'b000110;
  localparam logic [ID_W-1:0] ID_TMO  = 6'b001100;
  localparam logic [ID_W-1:0] ID_RXD  = 6'b000100;
  localparam logic [ID_W-1:0] ID_TX   = 6'b000010;
  localparam logic [ID_W-1:0] ID_MS   = 6'b000000;
  localparam logic [ID_W-1:0] ID_XF   = 6'b010000;
  localparam logic [ID_W-1:0] ID_FC   = 6'b100000;

  // enabled pending sources, highest priority first
  typedef struct packed {
    logic ls;
    logic tmo;
    logic rxd;
    logic tx;
    logic ms;
    logic xf;
    logic fc;
  } pend_t;

  function automatic logic [ID_W-1:0] pick_code(input pend_t p);
    logic [ID_W-1:0] c;
    c = ID_NONE;
    if (p.fc)  c = ID_FC;
    if (p.xf)  c = ID_XF;
    if (p.ms)  c = ID_MS;
    if (p.tx)  c = ID_TX;
    if (p.rxd) c = ID_RXD;
    if (p.tmo) c = ID_TMO;
    if (p.ls)  c = ID_LS;
    return c;
  endfunction

endpackage

// File: rtl/uirq_src_latch.sv
module uirq_src_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);

  // R7
  clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o);

endmodule

// File: rtl/uirq_err_track.sv
module uirq_err_track #(
  parameter int DEPTH = 64,
  parameter int ERR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [ERR_W-1:0] push_err_i,
  input  logic             pop_i,
  input  logic             empty_i,
  input  logic [ERR_W-1:0] head_err_i,
  output logic             err_any_o,
  output logic [ERR_W-1:0] head_view_o
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] bad_cnt;
  logic             bad_in;
  logic             bad_out;

  assign bad_in  = push_i && (push_err_i != '0);
  assign bad_out = pop_i && !empty_i && (head_err_i != '0);

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] cur,
                                            input logic inc, input logic dec);
    logic [CNT_W-1:0] n;
    n = cur;
    if (inc && !dec) n = cur + CNT_W'(1);
    if (dec && !inc) n = cur - CNT_W'(1);
    return n;
  endfunction

  always_ff @(posedge clk or posedge rst) begin
    if (rst) bad_cnt <= '0;
    else     bad_cnt <= bump(bad_cnt, bad_in, bad_out);
  end

  assign err_any_o   = (bad_cnt != '0);
  assign head_view_o = empty_i ? '0 : head_err_i;

  // R3
  err_rise_chk: assert property (@(posedge clk) disable iff (rst)
    bad_in |=> err_any_o);

  // R3
  err_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (err_any_o && !bad_out) |=> err_any_o);

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    bad_cnt <= CNT_W'(DEPTH));

endmodule

// File: rtl/uirq_prio_sel.sv
module uirq_prio_sel
  import uirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            hold_i,
  input  pend_t           pend_i,
  output logic [ID_W-1:0] code_o
);

  logic [ID_W-1:0] code_nxt;
  assign code_nxt = pick_code(pend_i);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)          code_o <= ID_NONE;
    else if (!hold_i) code_o <= code_nxt;
  end

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> $stable(code_o));

  // R2
  ls_top_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_i.ls && !hold_i) |=> (code_o == ID_LS));

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uirq_pkg::*;
#(
  parameter int RXQ_DEPTH = 64,
  parameter int ERR_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ien,
  input  logic [5:0]       ien_wdata,
  input  logic             rd_ident,
  input  logic             rd_status,
  input  logic             rd_data,
  input  logic             rd_modem,
  input  logic             wr_thr,
  input  logic             overrun_evt,
  input  logic             timeout_evt,
  input  logic             rx_data_cond,
  input  logic             tx_empty_evt,
  input  logic             modem_evt,
  input  logic             xoff_evt,
  input  logic             xon_evt,
  input  logic             special_evt,
  input  logic             flow_evt,
  input  logic             rxq_push,
  input  logic [ERR_W-1:0] rxq_push_err,
  input  logic             rxq_pop,
  input  logic             rxq_empty,
  input  logic [ERR_W-1:0] rxq_head_err,
  input  logic             irq_gate,
  input  logic             irq_force,
  output logic [5:0]       ident_code,
  output logic             irq_out,
  output logic             irq_oe,
  output logic             err_any,
  output logic [ERR_W-1:0] head_err
);

  // latched source slots
  localparam int L_OVR = 0;
  localparam int L_TMO = 1;
  localparam int L_TXE = 2;
  localparam int L_MSR = 3;
  localparam int L_FC  = 4;
  localparam int NLAT  = 5;

  logic [EN_W-1:0] ien_q;
  logic            rd_ident_q;
  logic            ident_end;
  logic [NLAT-1:0] lat_set, lat_clr, lat_q;
  logic            xf_q, xf_special_q;
  logic            xf_set, xf_clr;
  pend_t           pend;

  // enable mask register
  always_ff @(posedge clk or posedge rst) begin
    if (rst)         ien_q <= '0;
    else if (wr_ien) ien_q <= ien_wdata;
  end

  // end of an identification access
  always_ff @(posedge clk or posedge rst) begin
    if (rst) rd_ident_q <= 1'b0;
    else     rd_ident_q <= rd_ident;
  end
  assign ident_end = rd_ident_q && !rd_ident;

  // set / clear rules of the plain latched sources
  always_comb begin
    lat_set        = '0;
    lat_clr        = '0;
    lat_set[L_OVR] = overrun_evt;
    lat_clr[L_OVR] = rd_status;
    lat_set[L_TMO] = timeout_evt;
    lat_clr[L_TMO] = rd_data;
    lat_set[L_TXE] = tx_empty_evt;
    lat_clr[L_TXE] = wr_thr || (ident_end && ident_code == ID_TX);
    lat_set[L_MSR] = modem_evt;
    lat_clr[L_MSR] = rd_modem;
    lat_set[L_FC]  = flow_evt;
    lat_clr[L_FC]  = ident_end && ident_code == ID_FC;
  end

  for (genvar i = 0; i < NLAT; i++) begin : g_lat
    uirq_src_latch u_lat (
      .clk  (clk),
      .rst  (rst),
      .set_i(lat_set[i]),
      .clr_i(lat_clr[i]),
      .q_o  (lat_q[i])
    );
  end

  // Xoff source remembers what raised it
  assign xf_set = xoff_evt || special_evt;
  assign xf_clr = xf_special_q ? (ident_end && ident_code == ID_XF) : xon_evt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      xf_q         <= 1'b0;
      xf_special_q <= 1'b0;
    end else if (xf_set) begin
      xf_q         <= 1'b1;
      xf_special_q <= !xoff_evt;
    end else if (xf_q && xf_clr) begin
      xf_q         <= 1'b0;
      xf_special_q <= 1'b0;
    end
  end

  // error summary and head error view
  uirq_err_track #(.DEPTH(RXQ_DEPTH), .ERR_W(ERR_W)) u_err (
    .clk        (clk),
    .rst        (rst),
    .push_i     (rxq_push),
    .push_err_i (rxq_push_err),
    .pop_i      (rxq_pop),
    .empty_i    (rxq_empty),
    .head_err_i (rxq_head_err),
    .err_any_o  (err_any),
    .head_view_o(head_err)
  );

  // enabled pending sources
  always_comb begin
    pend.ls  = ien_q[EN_LS] && (lat_q[L_OVR] || err_any);
    pend.tmo = ien_q[EN_RX] && lat_q[L_TMO];
    pend.rxd = ien_q[EN_RX] && rx_data_cond;
    pend.tx  = ien_q[EN_TX] && lat_q[L_TXE];
    pend.ms  = ien_q[EN_MS] && lat_q[L_MSR];
    pend.xf  = ien_q[EN_XF] && xf_q;
    pend.fc  = ien_q[EN_FC] && lat_q[L_FC];
  end

  uirq_prio_sel u_sel (
    .clk   (clk),
    .rst   (rst),
    .hold_i(rd_ident),
    .pend_i(pend),
    .code_o(ident_code)
  );

  assign irq_out = |pend;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) irq_oe <= 1'b0;
    else     irq_oe <= irq_gate || irq_force;
  end

  // R9
  fc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ident_end && ident_code == ID_FC && !flow_evt) |=> !lat_q[L_FC]);

  // R8
  xoff_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (xf_q && !xf_special_q && !xon_evt) |=> xf_q);

  // R12
  oe_on_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_gate || irq_force) |=> irq_oe);

  // R12
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_gate && !irq_force) |=> !irq_oe);

  // R3
  ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_status && !overrun_evt) |=> !lat_q[L_OVR]);

endmodule

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_ien, rd_ident, rd_status, rd_data, rd_modem, wr_thr;
  logic [5:0] ien_wdata;
  logic overrun_evt, timeout_evt, rx_data_cond, tx_empty_evt, modem_evt;
  logic xoff_evt, xon_evt, special_evt, flow_evt;
  logic rxq_push, rxq_pop, rxq_empty, irq_gate, irq_force;
  logic [2:0] rxq_push_err, rxq_head_err;
  logic [5:0] ident_code;
  logic irq_out, irq_oe, err_any;
  logic [2:0] head_err;

  always #10 clk = ~clk;

  uart_irq_ident uut (.*);

  int total = 0;
  int fails = 0;

  // reference model state
  logic [5:0] m_ien, m_code;
  bit m_ovr, m_tmo, m_txe, m_msr, m_fc, m_xf, m_xs, m_rdq, m_oe;
  logic [2:0] qmem [64];
  int q_rd, q_cnt;

  function automatic bit q_bad();
    for (int k = 0; k < q_cnt; k++)
      if (qmem[(q_rd + k) % 64] != 3'b000) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [5:0] code_at(int lvl);
    case (lvl)
      0: return 6'b000110;
      1: return 6'b001100;
      2: return 6'b000100;
      3: return 6'b000010;
      4: return 6'b000000;
      5: return 6'b010000;
      6: return 6'b100000;
      default: return 6'b000001;
    endcase
  endfunction

  function automatic bit [6:0] active_vec(bit rxc);
    bit [6:0] v;
    v[0] = m_ien[2] & (m_ovr | q_bad());
    v[1] = m_ien[0] & m_tmo;
    v[2] = m_ien[0] & rxc;
    v[3] = m_ien[1] & m_txe;
    v[4] = m_ien[3] & m_msr;
    v[5] = m_ien[4] & m_xf;
    v[6] = m_ien[5] & m_fc;
    return v;
  endfunction

  function automatic logic [5:0] exp_code(bit [6:0] v);
    for (int i = 0; i < 7; i++) if (v[i]) return code_at(i);
    return 6'b000001;
  endfunction

  task automatic model_step();
    logic [5:0] nc;
    bit iend;
    nc   = rd_ident ? m_code : exp_code(active_vec(rx_data_cond));
    iend = m_rdq && !rd_ident;
    m_ovr = overrun_evt ? 1'b1 : (rd_status ? 1'b0 : m_ovr);
    m_tmo = timeout_evt ? 1'b1 : (rd_data ? 1'b0 : m_tmo);
    m_txe = tx_empty_evt ? 1'b1 : ((wr_thr || (iend && m_code == 6'b000010)) ? 1'b0 : m_txe);
    m_msr = modem_evt ? 1'b1 : (rd_modem ? 1'b0 : m_msr);
    m_fc  = flow_evt ? 1'b1 : ((iend && m_code == 6'b100000) ? 1'b0 : m_fc);
    if (xoff_evt || special_evt) begin
      m_xf = 1'b1; m_xs = !xoff_evt;
    end else if (m_xf && ((m_xs && iend && m_code == 6'b010000) || (!m_xs && xon_evt))) begin
      m_xf = 1'b0; m_xs = 1'b0;
    end
    if (rxq_pop && q_cnt > 0) begin q_rd = (q_rd + 1) % 64; q_cnt--; end
    if (rxq_push && q_cnt < 64) begin qmem[(q_rd + q_cnt) % 64] = rxq_push_err; q_cnt++; end
    if (wr_ien) m_ien = ien_wdata;
    m_code = nc;
    m_rdq  = rd_ident;
    m_oe   = irq_gate | irq_force;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive_head();
    rxq_empty = (q_cnt == 0);
    rxq_head_err = (q_cnt == 0) ? 3'($urandom) : qmem[q_rd];
  endtask

  task automatic clear_pulses();
    wr_ien = 0; rd_status = 0; rd_data = 0; rd_modem = 0; wr_thr = 0;
    overrun_evt = 0; timeout_evt = 0; tx_empty_evt = 0; modem_evt = 0;
    xoff_evt = 0; xon_evt = 0; special_evt = 0; flow_evt = 0;
    rxq_push = 0; rxq_pop = 0; rxq_push_err = 0;
  endtask

  // one clock: model steps on the rising edge, outputs compared after
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic check_all(string tag);
    chk(ident_code == m_code, {tag, " R2 code"}, ident_code, m_code);
    chk(irq_out == |active_vec(rx_data_cond), {tag, " R11 irq"}, irq_out, |active_vec(rx_data_cond));
    chk(err_any == q_bad(), {tag, " R3 err_any"}, err_any, q_bad());
    chk(irq_oe == m_oe, {tag, " R12 oe"}, irq_oe, m_oe);
  endtask

  task automatic step_pulse();
    tick(); check_all("dir");
    clear_pulses(); drive_head(); #1;
  endtask

  task automatic expect_code(logic [5:0] e, string tag);
    chk(ident_code == e, tag, ident_code, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_pulses();
    rd_ident = 0; rx_data_cond = 0; irq_gate = 0; irq_force = 0; ien_wdata = 0;
    m_ien = 0; m_code = 6'b000001; q_rd = 0; q_cnt = 0;
    {m_ovr, m_tmo, m_txe, m_msr, m_fc, m_xf, m_xs, m_rdq, m_oe} = '0;
    drive_head();
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state
    chk(ident_code == 6'b000001, "R1 reset code", ident_code, 1);
    chk(irq_out == 0, "R1 reset irq", irq_out, 0);
    chk(irq_oe == 0, "R1 reset oe", irq_oe, 0);
    tx_empty_evt = 1; step_pulse(); step_pulse();
    chk(irq_out == 0, "R1 enables cleared irq", irq_out, 0);
    expect_code(6'b000001, "R1 enables cleared code");
    wr_thr = 1; step_pulse();

    ien_wdata = 6'h3f; wr_ien = 1; step_pulse();
    // R6 / R7 transmit over modem
    tx_empty_evt = 1; step_pulse();
    chk(irq_out == 1, "R11 irq one cycle after event", irq_out, 1);
    step_pulse(); expect_code(6'b000010, "R6 tx code");
    modem_evt = 1; step_pulse(); step_pulse(); expect_code(6'b000010, "R2 tx above modem");
    wr_thr = 1; step_pulse(); step_pulse(); expect_code(6'b000000, "R6 thr write clears");
    rd_modem = 1; step_pulse(); step_pulse(); expect_code(6'b000001, "R7 modem read clears");

    // R3 error tracking and overrun
    rxq_push = 1; rxq_push_err = 3'b100; step_pulse();
    rxq_push = 1; rxq_push_err = 3'b000; step_pulse();
    chk(err_any == 1, "R3 err_any set", err_any, 1);
    expect_code(6'b000110, "R3 line status code");
    chk(head_err == 3'b100, "R4 head bits", head_err, 4);
    rxq_pop = 1; step_pulse();
    chk(err_any == 0, "R3 err_any falls after bad pop", err_any, 0);
    rxq_pop = 1; step_pulse();
    chk(head_err == 3'b000, "R4 empty head reads zero", head_err, 0);
    step_pulse(); expect_code(6'b000001, "R3 cleared after pops");
    overrun_evt = 1; step_pulse(); step_pulse(); expect_code(6'b000110, "R3 overrun");
    rd_status = 1; step_pulse(); step_pulse(); expect_code(6'b000001, "R3 status read clears");

    // R10 / R9 freeze and reported-only clearing
    flow_evt = 1; step_pulse(); step_pulse(); expect_code(6'b100000, "R9 flow code");
    rd_ident = 1; modem_evt = 1; step_pulse(); expect_code(6'b100000, "R10 frozen 1");
    step_pulse(); expect_code(6'b100000, "R10 frozen 2");
    rd_ident = 0; step_pulse(); step_pulse(); expect_code(6'b000000, "R10 released");
    rd_modem = 1; step_pulse(); step_pulse(); expect_code(6'b000001, "R9 flow cleared by ident read");
    flow_evt = 1; modem_evt = 1; step_pulse(); step_pulse();
    rd_ident = 1; step_pulse(); rd_ident = 0; step_pulse();
    rd_modem = 1; step_pulse(); step_pulse(); expect_code(6'b100000, "R10 unreported kept");
    rd_ident = 1; step_pulse(); rd_ident = 0; step_pulse(); step_pulse();
    expect_code(6'b000001, "R9 cleared when reported");

    // R8 Xoff causes
    xoff_evt = 1; step_pulse(); step_pulse(); expect_code(6'b010000, "R8 xoff code");
    rd_ident = 1; step_pulse(); rd_ident = 0; step_pulse(); step_pulse();
    expect_code(6'b010000, "R8 ident read ignored for flow xoff");
    xon_evt = 1; step_pulse(); step_pulse(); expect_code(6'b000001, "R8 xon clears");
    special_evt = 1; step_pulse(); xon_evt = 1; step_pulse(); step_pulse();
    expect_code(6'b010000, "R8 xon ignored for special");
    rd_ident = 1; step_pulse(); rd_ident = 0; step_pulse(); step_pulse();
    expect_code(6'b000001, "R8 special cleared by ident read");

    // R5 timeout vs receive data
    rx_data_cond = 1; timeout_evt = 1; step_pulse(); step_pulse();
    expect_code(6'b001100, "R5 timeout above rx data");
    rd_data = 1; step_pulse(); step_pulse(); expect_code(6'b000100, "R5 data read clears timeout");
    rx_data_cond = 0; step_pulse(); step_pulse(); expect_code(6'b000001, "R5 rx level drop");

    // R11 disabled source hidden
    ien_wdata = 6'h3d; wr_ien = 1; step_pulse();
    tx_empty_evt = 1; step_pulse(); step_pulse();
    chk(irq_out == 0, "R11 disabled tx no irq", irq_out, 0);
    expect_code(6'b000001, "R11 disabled tx no code");
    wr_thr = 1; step_pulse();

    // R12 output enable
    irq_force = 1; step_pulse(); chk(irq_oe == 1, "R12 force", irq_oe, 1);
    irq_force = 0; step_pulse(); chk(irq_oe == 0, "R12 off", irq_oe, 0);
    irq_gate = 1; step_pulse(); chk(irq_oe == 1, "R12 gate", irq_oe, 1);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      wr_ien = ($urandom % 40 == 0); ien_wdata = 6'($urandom);
      rd_ident = ($urandom % 5 == 0);
      rd_status = ($urandom % 9 == 0); rd_data = ($urandom % 9 == 0);
      rd_modem = ($urandom % 9 == 0); wr_thr = ($urandom % 9 == 0);
      overrun_evt = ($urandom % 15 == 0); timeout_evt = ($urandom % 12 == 0);
      tx_empty_evt = ($urandom % 8 == 0); modem_evt = ($urandom % 10 == 0);
      xoff_evt = ($urandom % 14 == 0); xon_evt = ($urandom % 10 == 0);
      special_evt = ($urandom % 14 == 0); flow_evt = ($urandom % 12 == 0);
      if ($urandom % 20 == 0) rx_data_cond = ~rx_data_cond;
      if ($urandom % 30 == 0) irq_gate = ~irq_gate;
      if ($urandom % 30 == 0) irq_force = ~irq_force;
      rxq_push = (q_cnt < 64) && ($urandom % 3 == 0);
      rxq_push_err = ($urandom % 4 == 0) ? 3'($urandom) : 3'b000;
      rxq_pop = (q_cnt > 0) && ($urandom % 3 == 0);
      tick();
      check_all("rand");
      clear_pulses(); drive_head(); #1;
      chk(head_err == ((q_cnt == 0) ? 3'b000 : qmem[q_rd]), "R4 head view",
          head_err, (q_cnt == 0) ? 0 : qmem[q_rd]);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule